// File: doc/BRIEF.md
# Disk DMA transfer sequencer

This block runs a single storage DMA transaction between a drive-side data path and a descriptor-driven DMA engine. A start command carries the drive kind (disk or optical), a count, a starting block address and, for disks, a direction. For a disk the count is in 512-byte sectors. For an optical drive it is a packet length in bytes. On start the sequencer loads its remaining-byte tally, clears its byte index and pulses a kick to the DMA engine.

The engine then offers host-memory chunks one at a time, each with an address and a length. For each chunk the sequencer either consumes it or ends it. A consumed chunk becomes a storage request carrying the byte offset on the medium. A chunk is ended without consumption when it is empty, when the transaction is complete, or when the transaction has failed. When the optical block address is all ones, there is no media request. The block instead asks for a direct buffer copy of the shorter of the remaining count and the chunk length. Completion depends on the remaining byte count and not on chunk exhaustion. A storage error ends the transaction through a separate error status.

Top module: `dma_xfer_seq`

## Requirements
- R1: A start in idle loads the transaction, raises busy_o and pulses kick_o for one cycle with status_o cleared to 0. A start while busy is ignored: no kick and no change to the transaction.
- R2: A consumed chunk issues a one-cycle request with req_addr_o and req_len_o taken from the chunk. req_offset_o is (block address << 11) + byte index for an optical drive and (sector << 9) + byte index for a disk. The byte index is the sum of the lengths consumed before this chunk.
- R3: At start the remaining count is the byte count (optical, kind_i=1) or count×512 (disk, kind_i=0). Each request subtracts its length and may overshoot below zero. A good response pulses chunk_done_o. If the remaining count is then ≤0 the transfer finishes with status 1; otherwise it waits for the next chunk.
- R4: A chunk offered while idle is left unconsumed. chunk_wait_o pulses and there is no chunk_done_o and no request.
- R5: A chunk offered while busy with a remaining count ≤0 finishes the transfer with status 1 and issues no request.
- R6: A zero-length chunk with bytes remaining pulses chunk_done_o only. The transfer stays busy and no request is issued.
- R7: For an optical drive with block address all ones, a non-empty chunk issues no request. Instead copy_valid_o pulses with the chunk address and copy_len_o = min(remaining, chunk length), and the transfer finishes with status 1.
- R8: A response with rsp_err_i set finishes the transfer with status 3 for an optical drive and status 2 for a disk.
- R9: The disk direction dir_i sets req_op_o: 0 read, 1 write, 2 trim. Value 3 ends the transfer at the first non-empty chunk with status 4 and no request. Optical requests always carry op 0.
- R10: Every finish pulses done_o and irq_o for one cycle, drops busy_o in the same cycle and holds status_o until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start command strobe |
| kind_i | input | 1 | Drive kind: 0 disk, 1 optical |
| dir_i | input | 2 | Disk direction: 0 read, 1 write, 2 trim, 3 illegal |
| count_i | input | CNT_W | Sector count (disk) or byte count (optical) |
| lba_i | input | LBA_W | Starting sector or block address |
| kick_o | output | 1 | One-cycle kick to the DMA engine |
| busy_o | output | 1 | Transaction active |
| chunk_valid_i | input | 1 | DMA engine offers a chunk |
| chunk_addr_i | input | ADDR_W | Chunk host address |
| chunk_len_i | input | LEN_W | Chunk length in bytes |
| chunk_done_o | output | 1 | Chunk ended, one cycle |
| chunk_wait_o | output | 1 | Chunk left unconsumed (not active), one cycle |
| req_valid_o | output | 1 | Storage request strobe |
| req_op_o | output | 2 | Request operation: 0 read, 1 write, 2 trim |
| req_offset_o | output | OFF_W | Storage byte offset |
| req_addr_o | output | ADDR_W | Host address of the request |
| req_len_o | output | LEN_W | Request length in bytes |
| rsp_valid_i | input | 1 | Storage response strobe |
| rsp_err_i | input | 1 | Storage response is an error |
| copy_valid_o | output | 1 | Direct buffer copy strobe |
| copy_addr_o | output | ADDR_W | Copy destination address |
| copy_len_o | output | LEN_W | Copy length in bytes |
| done_o | output | 1 | Transfer finished, one cycle |
| irq_o | output | 1 | Drive interrupt, one cycle |
| status_o | output | 3 | 0 none, 1 ok, 2 disk DMA error, 3 optical I/O error, 4 illegal command |

## Verification
The assertions assume that the storage side answers only while a request is outstanding and that the DMA engine offers no chunk while a response is pending. The arithmetic checks also assume chunk lengths stay within LEN_W. The bench keeps to these rules by construction: it offers a chunk only when no request is open and sends exactly one response after each issued request, with a short random delay. Random transactions mix drive kinds, all four direction codes, zero and overshooting chunk lengths, the all-ones optical address, injected errors, chunks while idle and stray starts while busy.

// File: rtl/dxs_pkg.sv
package dxs_pkg;
  typedef enum logic {KIND_DISK = 1'b0, KIND_OPTICAL = 1'b1} kind_e;
  typedef enum logic [1:0] {DIR_READ = 2'd0, DIR_WRITE = 2'd1, DIR_TRIM = 2'd2, DIR_BAD = 2'd3} dir_e;
  typedef enum logic [2:0] {
    ST_NONE = 3'd0, ST_OK = 3'd1, ST_DMA_ERR = 3'd2, ST_PKT_ERR = 3'd3, ST_BAD_CMD = 3'd4
  } stat_e;
  typedef enum logic [1:0] {S_IDLE, S_WAIT_CHUNK, S_WAIT_RSP} state_e;
  localparam int OPT_SHIFT  = 11;
  localparam int DISK_SHIFT = 9;
endpackage

// File: rtl/dxs_offset.sv
module dxs_offset
  import dxs_pkg::*;
#(
  parameter int LBA_W = 32,
  parameter int IDX_W = 27,
  parameter int OFF_W = 44
) (
  input  logic             optical_i,
  input  logic [LBA_W-1:0] lba_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [OFF_W-1:0] off_o
);
  logic [OFF_W-1:0] base;

  always_comb begin
    if (optical_i) base = OFF_W'(lba_i) << OPT_SHIFT;
    else           base = OFF_W'(lba_i) << DISK_SHIFT;
    off_o = base + OFF_W'(idx_i);
  end
endmodule

// File: rtl/dxs_tally.sv
module dxs_tally
  import dxs_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int LEN_W = 16,
  parameter int REM_W = 27
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             kind_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             consume_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [REM_W-1:0] idx_o,
  output logic             empty_o,
  output logic [LEN_W-1:0] copy_len_o
);
  logic signed [REM_W-1:0] rem_q, len_s, load_val;
  logic        [REM_W-1:0] idx_q;

  assign len_s    = $signed(REM_W'(len_i));
  assign load_val = kind_i ? $signed(REM_W'(count_i)) : $signed(REM_W'(count_i) << DISK_SHIFT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
      idx_q <= '0;
    end else if (load_i) begin
      rem_q <= load_val;
      idx_q <= '0;
    end else if (consume_i) begin
      rem_q <= rem_q - len_s;
      idx_q <= idx_q + REM_W'(len_i);
    end
  end

  assign idx_o      = idx_q;
  assign empty_o    = rem_q[REM_W-1] || (rem_q == '0);
  assign copy_len_o = (rem_q < len_s) ? rem_q[LEN_W-1:0] : len_i;

  assert_consume_sub_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    consume_i |=> (rem_q == $past(rem_q) - $past(len_s)) && (idx_q == $past(idx_q) + REM_W'($past(len_i))));
  assert_load_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> idx_q == '0);
  assert_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_i && consume_i));
endmodule

// File: rtl/dxs_ctrl.sv
module dxs_ctrl
  import dxs_pkg::*;
#(
  parameter int LBA_W  = 32,
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int OFF_W  = 44
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              kind_i,
  input  logic [1:0]        dir_i,
  input  logic [LBA_W-1:0]  lba_i,
  input  logic              chunk_valid_i,
  input  logic [ADDR_W-1:0] chunk_addr_i,
  input  logic [LEN_W-1:0]  chunk_len_i,
  input  logic              rsp_valid_i,
  input  logic              rsp_err_i,
  input  logic              empty_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [LEN_W-1:0]  copy_len_i,
  output logic              load_o,
  output logic              consume_o,
  output logic              kind_o,
  output logic [LBA_W-1:0]  lba_o,
  output logic              kick_o,
  output logic              busy_o,
  output logic              chunk_done_o,
  output logic              chunk_wait_o,
  output logic              req_valid_o,
  output logic [1:0]        req_op_o,
  output logic [OFF_W-1:0]  req_offset_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [LEN_W-1:0]  req_len_o,
  output logic              copy_valid_o,
  output logic [ADDR_W-1:0] copy_addr_o,
  output logic [LEN_W-1:0]  copy_len_o,
  output logic              done_o,
  output logic              irq_o,
  output logic [2:0]        status_o
);
  state_e           state_q;
  kind_e            kind_q;
  dir_e             dir_q;
  logic [LBA_W-1:0] lba_q;
  logic             sentinel, bad_dir, in_chunk, len_zero;

  assign sentinel  = (kind_q == KIND_OPTICAL) && (&lba_q);
  assign bad_dir   = (kind_q == KIND_DISK) && (dir_q == DIR_BAD);
  assign len_zero  = (chunk_len_i == '0);
  assign in_chunk  = (state_q == S_WAIT_CHUNK) && chunk_valid_i;
  assign load_o    = (state_q == S_IDLE) && start_i;
  assign consume_o = in_chunk && !empty_i && !len_zero && !sentinel && !bad_dir;
  assign kind_o    = kind_q;
  assign lba_o     = lba_q;
  assign busy_o    = (state_q != S_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= S_IDLE;
      kind_q       <= KIND_DISK;
      dir_q        <= DIR_READ;
      lba_q        <= '0;
      kick_o       <= 1'b0;
      chunk_done_o <= 1'b0;
      chunk_wait_o <= 1'b0;
      req_valid_o  <= 1'b0;
      req_op_o     <= '0;
      req_offset_o <= '0;
      req_addr_o   <= '0;
      req_len_o    <= '0;
      copy_valid_o <= 1'b0;
      copy_addr_o  <= '0;
      copy_len_o   <= '0;
      done_o       <= 1'b0;
      irq_o        <= 1'b0;
      status_o     <= ST_NONE;
    end else begin
      kick_o       <= 1'b0;
      chunk_done_o <= 1'b0;
      chunk_wait_o <= 1'b0;
      req_valid_o  <= 1'b0;
      copy_valid_o <= 1'b0;
      done_o       <= 1'b0;
      irq_o        <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          chunk_wait_o <= chunk_valid_i;
          if (start_i) begin
            kind_q   <= kind_e'(kind_i);
            dir_q    <= dir_e'(dir_i);
            lba_q    <= lba_i;
            status_o <= ST_NONE;
            kick_o   <= 1'b1;
            state_q  <= S_WAIT_CHUNK;
          end
        end
        S_WAIT_CHUNK: begin
          if (consume_o) begin
            req_valid_o  <= 1'b1;
            req_offset_o <= off_i;
            req_addr_o   <= chunk_addr_i;
            req_len_o    <= chunk_len_i;
            req_op_o     <= (kind_q == KIND_OPTICAL) ? DIR_READ : dir_q;
            state_q      <= S_WAIT_RSP;
          end else if (chunk_valid_i) begin
            chunk_done_o <= 1'b1;
            if (empty_i) begin
              done_o   <= 1'b1;
              irq_o    <= 1'b1;
              status_o <= ST_OK;
              state_q  <= S_IDLE;
            end else if (sentinel && !len_zero) begin
              copy_valid_o <= 1'b1;
              copy_addr_o  <= chunk_addr_i;
              copy_len_o   <= copy_len_i;
              done_o       <= 1'b1;
              irq_o        <= 1'b1;
              status_o     <= ST_OK;
              state_q      <= S_IDLE;
            end else if (bad_dir && !len_zero) begin
              done_o   <= 1'b1;
              irq_o    <= 1'b1;
              status_o <= ST_BAD_CMD;
              state_q  <= S_IDLE;
            end
          end
        end
        S_WAIT_RSP: begin
          if (rsp_valid_i) begin
            chunk_done_o <= 1'b1;
            if (rsp_err_i) begin
              done_o   <= 1'b1;
              irq_o    <= 1'b1;
              status_o <= (kind_q == KIND_OPTICAL) ? ST_PKT_ERR : ST_DMA_ERR;
              state_q  <= S_IDLE;
            end else if (empty_i) begin
              done_o   <= 1'b1;
              irq_o    <= 1'b1;
              status_o <= ST_OK;
              state_q  <= S_IDLE;
            end else begin
              state_q <= S_WAIT_CHUNK;
            end
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assert_kick_busy_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_o |-> busy_o && (status_o == ST_NONE));
  assert_req_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |=> !req_valid_o);
  assert_wait_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chunk_wait_o |-> !chunk_done_o && !req_valid_o && !$past(busy_o));
  assert_req_nonzero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> (req_len_o != '0) && !chunk_done_o);
  assert_copy_len_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    copy_valid_o |-> (copy_len_o <= $past(chunk_len_i)) && (copy_len_o != '0));
  assert_done_exit_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && irq_o);
  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && $stable(status_o));
endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq #(
  parameter int CNT_W  = 16,
  parameter int LEN_W  = 16,
  parameter int LBA_W  = 32,
  parameter int ADDR_W = 32,
  localparam int REM_W = ((CNT_W + 9 > LEN_W) ? CNT_W + 9 : LEN_W) + 2,
  localparam int OFF_W = ((LBA_W + 11 > REM_W) ? LBA_W + 11 : REM_W) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              kind_i,
  input  logic [1:0]        dir_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [LBA_W-1:0]  lba_i,
  output logic              kick_o,
  output logic              busy_o,
  input  logic              chunk_valid_i,
  input  logic [ADDR_W-1:0] chunk_addr_i,
  input  logic [LEN_W-1:0]  chunk_len_i,
  output logic              chunk_done_o,
  output logic              chunk_wait_o,
  output logic              req_valid_o,
  output logic [1:0]        req_op_o,
  output logic [OFF_W-1:0]  req_offset_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [LEN_W-1:0]  req_len_o,
  input  logic              rsp_valid_i,
  input  logic              rsp_err_i,
  output logic              copy_valid_o,
  output logic [ADDR_W-1:0] copy_addr_o,
  output logic [LEN_W-1:0]  copy_len_o,
  output logic              done_o,
  output logic              irq_o,
  output logic [2:0]        status_o
);
  logic             load, consume, empty, kind_q;
  logic [REM_W-1:0] idx;
  logic [LEN_W-1:0] copy_len;
  logic [OFF_W-1:0] off;
  logic [LBA_W-1:0] lba_q;

  dxs_tally #(.CNT_W(CNT_W), .LEN_W(LEN_W), .REM_W(REM_W)) u_tally (
    .clk_i, .rst_ni,
    .load_i(load), .kind_i, .count_i,
    .consume_i(consume), .len_i(chunk_len_i),
    .idx_o(idx), .empty_o(empty), .copy_len_o(copy_len)
  );

  dxs_offset #(.LBA_W(LBA_W), .IDX_W(REM_W), .OFF_W(OFF_W)) u_offset (
    .optical_i(kind_q), .lba_i(lba_q), .idx_i(idx), .off_o(off)
  );

  dxs_ctrl #(.LBA_W(LBA_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .OFF_W(OFF_W)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .kind_i, .dir_i, .lba_i,
    .chunk_valid_i, .chunk_addr_i, .chunk_len_i, .rsp_valid_i, .rsp_err_i,
    .empty_i(empty), .off_i(off), .copy_len_i(copy_len),
    .load_o(load), .consume_o(consume), .kind_o(kind_q), .lba_o(lba_q),
    .kick_o, .busy_o, .chunk_done_o, .chunk_wait_o,
    .req_valid_o, .req_op_o, .req_offset_o, .req_addr_o, .req_len_o,
    .copy_valid_o, .copy_addr_o, .copy_len_o, .done_o, .irq_o, .status_o
  );
endmodule

// File: tb/dma_xfer_seq_bench.sv
module dma_xfer_seq_bench;
  timeunit 1ns;
  timeprecision 1ps;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_ni, start_i, kind_i, chunk_valid_i, rsp_valid_i, rsp_err_i;
  logic [1:0]  dir_i;
  logic [15:0] count_i, chunk_len_i;
  logic [31:0] lba_i, chunk_addr_i;
  logic        kick_o, busy_o, chunk_done_o, chunk_wait_o, req_valid_o, copy_valid_o, done_o, irq_o;
  logic [1:0]  req_op_o;
  logic [43:0] req_offset_o;
  logic [31:0] req_addr_o, copy_addr_o;
  logic [15:0] req_len_o, copy_len_o;
  logic [2:0]  status_o;

  dma_xfer_seq u_dma_xfer_seq (.*, .clk_i(clk));

  int n_chk = 0, n_err = 0;
  bit     m_busy = 0, m_kind = 0, m_pend = 0;
  int     m_dir = 0;
  longint m_lba = 0, m_rem = 0, m_idx = 0;

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic longint exp_offset();
    return m_kind ? (m_lba << 11) + m_idx : (m_lba << 9) + m_idx;
  endfunction

  task automatic expect_fin(input string tag, input int st);
    chk({tag, " done"}, done_o, 1);
    chk({tag, " irq"}, irq_o, 1);
    chk({tag, " busy drop R10"}, busy_o, 0);
    chk({tag, " status"}, status_o, st);
    m_busy = 0;
    step();
    chk("R10 done single cycle", done_o, 0);
    chk("R10 irq single cycle", irq_o, 0);
    chk("R10 status held", status_o, st);
  endtask

  task automatic do_start(input bit k, input int d, input int c, input longint l);
    kind_i = k; dir_i = 2'(d); count_i = 16'(c); lba_i = 32'(l); start_i = 1'b1;
    step();
    start_i = 1'b0;
    if (!m_busy) begin
      m_busy = 1; m_kind = k; m_dir = d; m_lba = l; m_idx = 0;
      m_rem = k ? longint'(c) : longint'(c) * 512;
      chk("R1 kick", kick_o, 1);
      chk("R1 busy", busy_o, 1);
      chk("R1 status cleared", status_o, 0);
    end else begin
      chk("R1 start ignored kick", kick_o, 0);
      chk("R1 start ignored busy", busy_o, 1);
    end
  endtask

  task automatic do_chunk(input logic [31:0] a, input int len);
    longint exp_cl;
    chunk_valid_i = 1'b1; chunk_addr_i = a; chunk_len_i = 16'(len);
    step();
    chunk_valid_i = 1'b0;
    if (!m_busy) begin
      chk("R4 wait pulse", chunk_wait_o, 1);
      chk("R4 no chunk_done", chunk_done_o, 0);
      chk("R4 no request", req_valid_o, 0);
    end else if (m_rem <= 0) begin
      chk("R5 chunk_done", chunk_done_o, 1);
      chk("R5 no request", req_valid_o, 0);
      expect_fin("R5", 1);
    end else if (len == 0) begin
      chk("R6 chunk_done", chunk_done_o, 1);
      chk("R6 busy", busy_o, 1);
      chk("R6 no request", req_valid_o, 0);
      chk("R6 no done", done_o, 0);
    end else if (m_kind && m_lba == 64'hFFFF_FFFF) begin
      exp_cl = (m_rem < len) ? m_rem : len;
      chk("R7 copy valid", copy_valid_o, 1);
      chk("R7 copy len", copy_len_o, exp_cl);
      chk("R7 copy addr", copy_addr_o, a);
      chk("R7 no request", req_valid_o, 0);
      expect_fin("R7", 1);
    end else if (!m_kind && m_dir == 3) begin
      chk("R9 illegal no request", req_valid_o, 0);
      expect_fin("R9 illegal", 4);
    end else begin
      chk("R2 request", req_valid_o, 1);
      chk("R2 offset", longint'(req_offset_o), exp_offset());
      chk("R2 addr", req_addr_o, a);
      chk("R2 len", req_len_o, len);
      chk("R9 op", req_op_o, m_kind ? 0 : m_dir);
      chk("R3 no chunk_done on issue", chunk_done_o, 0);
      m_rem -= len; m_idx += len; m_pend = 1;
    end
  endtask

  task automatic do_rsp(input bit err);
    repeat ($urandom_range(0, 2)) step();
    rsp_valid_i = 1'b1; rsp_err_i = err;
    step();
    rsp_valid_i = 1'b0; rsp_err_i = 1'b0; m_pend = 0;
    chk("R3 chunk_done on response", chunk_done_o, 1);
    if (err) expect_fin("R8 error", m_kind ? 3 : 2);
    else if (m_rem <= 0) expect_fin("R3 complete", 1);
    else begin
      chk("R3 still busy", busy_o, 1);
      chk("R3 no done", done_o, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_ni = 1'b0; start_i = 0; kind_i = 0; dir_i = 0; count_i = 0; lba_i = 0;
    chunk_valid_i = 0; chunk_addr_i = 0; chunk_len_i = 0; rsp_valid_i = 0; rsp_err_i = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 reset busy", busy_o, 0);
    chk("R10 reset status", status_o, 0);
    chk("R10 reset done", done_o, 0);
    chk("R1 reset kick", kick_o, 0);

    do_chunk(32'h100, 64);                       // R4 idle chunk
    do_start(0, 0, 2, 5);                        // disk read, 2 sectors
    do_chunk(32'h1000, 512); do_rsp(0);
    do_chunk(32'h2000, 0);                       // R6
    do_chunk(32'h3000, 512); do_rsp(0);          // R3 completes
    do_start(0, 1, 1, 77);
    do_chunk(32'h4000, 1500); do_rsp(0);         // R3 overshoot
    do_start(0, 2, 1, 9);
    do_chunk(32'h5000, 512); do_rsp(0);          // R9 trim
    do_start(0, 3, 4, 9);
    do_chunk(32'h6000, 100);                     // R9 illegal
    do_start(1, 2, 4096, 3);
    do_chunk(32'h7000, 2048); do_rsp(1);         // R8 optical
    do_start(0, 0, 3, 12);
    do_chunk(32'h7100, 512); do_rsp(1);          // R8 disk
    do_start(1, 0, 40, 64'hFFFF_FFFF);
    do_chunk(32'h8000, 64);                      // R7 short remaining
    do_start(1, 0, 100, 64'hFFFF_FFFF);
    do_chunk(32'h8100, 64);                      // R7 short chunk
    do_start(0, 0, 0, 1);
    do_chunk(32'h9000, 10);                      // R5 zero count

    for (int t = 0; t < 400; t++) begin
      bit k;
      int d, c;
      longint l;
      k = 1'($urandom_range(0, 1));
      d = ($urandom_range(0, 9) == 0) ? 3 : int'($urandom_range(0, 2));
      c = k ? int'($urandom_range(0, 6000)) : int'($urandom_range(0, 8));
      l = ($urandom_range(0, 7) == 0) ? 64'hFFFF_FFFF : longint'($urandom);
      if ($urandom_range(0, 4) == 0) do_chunk($urandom, int'($urandom_range(0, 2048)));
      do_start(k, d, c, l);
      for (int g = 0; g < 64 && m_busy; g++) begin
        if ($urandom_range(0, 15) == 0)
          do_start(1'($urandom_range(0, 1)), int'($urandom_range(0, 3)), int'($urandom_range(0, 100)), longint'($urandom));
        do_chunk($urandom, ($urandom_range(0, 5) == 0) ? 0 : int'($urandom_range(1, 2048)));
        if (m_pend) do_rsp($urandom_range(0, 19) == 0);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule